// File: doc/BRIEF.md
# Error completion packet assembler

This block assembles the eight-Dword stream packet that a PCIe completer sends when it answers a request with Unsupported Request or Completer Abort status. A single start pulse loads three inputs into an internal eight-Dword buffer. The first is the three-Dword completion descriptor. The second is one sideband Dword rebuilt from the request's byte enables and processing-hint fields. The third is the four-Dword request descriptor that arrived with the original request. The receiver needs the last two parts so that it can log the failed request.

The block then sends the buffer as an AXI4-Stream packet on a master port. The data width is 64, 128 or 256 bits, chosen by parameter. The Dwords are packed with no gaps, and the buffer is split into as many beats as the width requires. The output honours tready backpressure. A busy flag shows that a packet is in progress. A one-cycle done pulse marks the cycle in which the sink accepts the last beat.

Top module: `errcpl_packer`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, m_tvalid, busy and done are 0. A reset in the middle of a packet drops m_tvalid.
- R2: When start is high while busy is low, a rising clock edge captures all packet inputs. From the next cycle, busy and m_tvalid are 1.
- R3: Packet Dwords 0, 1 and 2 are bits [31:0], [63:32] and [95:64] of cpl_desc.
- R4: Packet Dword 3 holds first_be in bits [3:0], last_be in [7:4], tph_present in [8], tph_type in [10:9] and tph_tag in [23:16]. All other bits are 0.
- R5: Packet Dwords 4 to 7 are req_desc[31:0], [63:32], [95:64] and [127:96], in that order.
- R6: A beat carries DATA_W/32 Dwords, with the lowest-numbered Dword in the lowest data bits. The packet takes 256/DATA_W beats.
- R7: m_tkeep has one bit per Dword and is all ones on every beat.
- R8: Once m_tvalid rises, it stays high on every cycle until the last beat is accepted.
- R9: m_tlast is high on the final beat only.
- R10: While m_tvalid is high and m_tready is low, m_tdata, m_tlast and m_tkeep keep their values into the next cycle.
- R11: Start is ignored while busy is high, including in the cycle where the final beat is accepted. The packet in flight is unchanged, and no new packet follows.
- R12: done is high exactly in the cycle where the final beat is accepted (m_tvalid, m_tready and m_tlast all high). In the following cycle, busy and m_tvalid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to build and send a packet |
| cpl_desc | input | 96 | Completion descriptor (three Dwords) |
| req_desc | input | 128 | Request descriptor captured with the request (four Dwords) |
| first_be | input | 4 | First-Dword byte enables of the request |
| last_be | input | 4 | Last-Dword byte enables of the request |
| tph_present | input | 1 | Processing hint present on the request |
| tph_type | input | 2 | Processing hint type |
| tph_tag | input | 8 | Processing hint steering tag |
| busy | output | 1 | Packet buffered or in transfer |
| done | output | 1 | Final beat accepted this cycle |
| m_tdata | output | DATA_W | Stream data |
| m_tkeep | output | DATA_W/32 | Stream Dword keep |
| m_tvalid | output | 1 | Stream valid |
| m_tlast | output | 1 | Last beat of packet |
| m_tready | input | 1 | Sink ready |

## Verification
Two things can happen in the same cycle: a new start request and the acceptance of the final beat, when busy is still high. The bench raises start with scrambled inputs on every cycle of some transfers, so the request lands on the final-accept cycle and also on stalled cycles. It judges the result in two ways. Every accepted beat must still carry the Dwords of the original vector. One cycle after done, m_tvalid and busy must both be low, which shows that no new packet was started.

// File: rtl/errcpl_packer.sv
module errcpl_packer #(
  parameter int DATA_W = 256
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [95:0]            cpl_desc,
  input  logic [127:0]           req_desc,
  input  logic [3:0]             first_be,
  input  logic [3:0]             last_be,
  input  logic                   tph_present,
  input  logic [1:0]             tph_type,
  input  logic [7:0]             tph_tag,
  output logic                   busy,
  output logic                   done,
  output logic [DATA_W-1:0]      m_tdata,
  output logic [DATA_W/32-1:0]   m_tkeep,
  output logic                   m_tvalid,
  output logic                   m_tlast,
  input  logic                   m_tready
);
  localparam int PKT_W = 256;
  localparam int DPB   = DATA_W / 32;
  localparam int BEATS = PKT_W / DATA_W;
  localparam int CW    = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [PKT_W-1:0] pkt;
  logic [CW-1:0]    beat;
  logic             busy_q;

  wire [31:0] side_dw = {8'h00, tph_tag, 5'b0, tph_type, tph_present, last_be, first_be};
  wire        take    = start && !busy_q;
  wire        accept  = busy_q && m_tready;
  wire        finish  = accept && m_tlast;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat   <= '0;
      pkt    <= '0;
    end else if (take) begin
      pkt    <= {req_desc, side_dw, cpl_desc};
      busy_q <= 1'b1;
      beat   <= '0;
    end else if (accept) begin
      if (finish) begin
        busy_q <= 1'b0;
        beat   <= '0;
      end else begin
        beat <= beat + 1'b1;
      end
    end
  end

  generate
    if (BEATS == 1) begin : g_one
      assign m_tdata = pkt[DATA_W-1:0];
      assign m_tlast = 1'b1;
    end else begin : g_multi
      logic [DATA_W-1:0] slice [BEATS];
      for (genvar g = 0; g < BEATS; g++) begin : g_slice
        assign slice[g] = pkt[g*DATA_W +: DATA_W];
      end
      assign m_tdata = slice[beat];
      assign m_tlast = (beat == CW'(BEATS - 1));
    end
  endgenerate

  assign m_tkeep  = {DPB{1'b1}};
  assign m_tvalid = busy_q;
  assign busy     = busy_q;
  assign done     = finish;

  // R2
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> m_tvalid && busy);

  // R3
  first_dword_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> m_tdata[31:0] == $past(cpl_desc[31:0]));

  // R8
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !(m_tready && m_tlast) |=> m_tvalid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast) && $stable(m_tkeep));

  // R11
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tready && m_tlast && start |=> !m_tvalid);

  // R12
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && !m_tvalid);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/errcpl_packer_test.sv
module errcpl_packer_test;
  localparam int W   = 64;
  localparam int DPB = W / 32;
  localparam int NB  = 256 / W;

  typedef struct packed {
    logic [95:0]  cpl;
    logic [127:0] req;
    logic [3:0]   fbe;
    logic [3:0]   lbe;
    logic         tp;
    logic [1:0]   tt;
    logic [7:0]   tag;
    logic [7:0]   rdy;
    logic         poke;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{cpl: 96'h0A0B0C0D_11223344_55667788, req: 128'hDEADBEEF_CAFEF00D_01234567_89ABCDEF,
      fbe: 4'hF, lbe: 4'h0, tp: 1'b0, tt: 2'd0, tag: 8'h00, rdy: 8'hFF, poke: 1'b0},
    '{cpl: 96'h13579BDF_2468ACE0_FEDCBA98, req: 128'h00000001_00000002_00000003_00000004,
      fbe: 4'h3, lbe: 4'hC, tp: 1'b1, tt: 2'd2, tag: 8'hA5, rdy: 8'b01010101, poke: 1'b1},
    '{cpl: 96'hFFFFFFFF_00000000_A5A5A5A5, req: 128'h80000000_7FFFFFFF_5A5A5A5A_C3C3C3C3,
      fbe: 4'h1, lbe: 4'h8, tp: 1'b1, tt: 2'd3, tag: 8'hFF, rdy: 8'b10011100, poke: 1'b0},
    '{cpl: 96'h31415926_53589793_23846264, req: 128'h27182818_28459045_23536028_74713526,
      fbe: 4'h6, lbe: 4'h9, tp: 1'b0, tt: 2'd1, tag: 8'h3C, rdy: 8'b10001000, poke: 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [95:0] cpl_desc = '0;
  logic [127:0] req_desc = '0;
  logic [3:0] first_be = '0, last_be = '0;
  logic tph_present = 1'b0;
  logic [1:0] tph_type = '0;
  logic [7:0] tph_tag = '0;
  logic busy, done, m_tvalid, m_tlast;
  logic m_tready = 1'b0;
  logic [W-1:0] m_tdata;
  logic [DPB-1:0] m_tkeep;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  errcpl_packer #(.DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cpl_desc(cpl_desc), .req_desc(req_desc),
    .first_be(first_be), .last_be(last_be), .tph_present(tph_present), .tph_type(tph_type),
    .tph_tag(tph_tag), .busy(busy), .done(done), .m_tdata(m_tdata), .m_tkeep(m_tkeep),
    .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tready(m_tready));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_dw(input vec_t v, input int i);
    if (i < 3) return v.cpl[32*i +: 32];
    if (i == 3) return {8'h00, v.tag, 5'b0, v.tt, v.tp, v.lbe, v.fbe};
    return v.req[32*(i-4) +: 32];
  endfunction

  task automatic drive(input vec_t v, input bit scramble);
    cpl_desc    = scramble ? ~v.cpl : v.cpl;
    req_desc    = scramble ? ~v.req : v.req;
    first_be    = scramble ? ~v.fbe : v.fbe;
    last_be     = scramble ? ~v.lbe : v.lbe;
    tph_present = scramble ? ~v.tp  : v.tp;
    tph_type    = scramble ? ~v.tt  : v.tt;
    tph_tag     = scramble ? ~v.tag : v.tag;
  endtask

  task automatic run_vec(input vec_t v);
    int got = 0;
    int cyc = 0;
    bit prev_stall = 0;
    logic [W-1:0] prev_data = '0;
    logic prev_last = 1'b0;
    @(negedge clk);
    drive(v, 1'b0);
    start = 1'b1;
    m_tready = 1'b0;
    @(negedge clk);
    start = v.poke;
    if (v.poke) drive(v, 1'b1);
    #1;
    check(busy === 1'b1, "R2", "busy after start", busy, 1);
    check(m_tvalid === 1'b1, "R2", "tvalid after start", m_tvalid, 1);
    while (got < NB && cyc < 64) begin
      m_tready = v.rdy[cyc % 8];
      #1;
      check(m_tvalid === 1'b1, "R8", "tvalid inside packet", m_tvalid, 1);
      check(m_tkeep === {DPB{1'b1}}, "R7", "tkeep", m_tkeep, {DPB{1'b1}});
      if (prev_stall) begin
        check(m_tdata === prev_data, "R10", "tdata held under stall", m_tdata, prev_data);
        check(m_tlast === prev_last, "R10", "tlast held under stall", m_tlast, prev_last);
      end
      if (m_tready) begin
        for (int d = 0; d < DPB; d++) begin
          int idx = got * DPB + d;
          string rq = (idx < 3) ? "R3" : ((idx == 3) ? "R4" : "R5");
          // R6: Dword idx sits at slot d of beat got
          check(m_tdata[32*d +: 32] === exp_dw(v, idx), rq, $sformatf("R6 dword %0d", idx),
                m_tdata[32*d +: 32], exp_dw(v, idx));
        end
        check(m_tlast === (got == NB - 1), "R9", "tlast", m_tlast, (got == NB - 1));
        check(done === (got == NB - 1), "R12", "done", done, (got == NB - 1));
        got++;
      end
      prev_stall = !m_tready;
      prev_data  = m_tdata;
      prev_last  = m_tlast;
      @(negedge clk);
      cyc++;
    end
    check(got == NB, "R6", "beats accepted", got, NB);
    start = 1'b0;
    m_tready = 1'b0;
    #1;
    check(m_tvalid === 1'b0, "R11", "no packet after final accept", m_tvalid, 0);
    check(busy === 1'b0, "R12", "busy cleared", busy, 0);
    check(done === 1'b0, "R12", "done single cycle", done, 0);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(m_tvalid === 1'b0, "R1", "tvalid in reset", m_tvalid, 0);
    check(busy === 1'b0, "R1", "busy in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done === 1'b0, "R1", "done after reset", done, 0);
    check(m_tvalid === 1'b0, "R1", "tvalid after reset", m_tvalid, 0);

    for (int i = 0; i < 4; i++) run_vec(VECS[i]);

    // R1: reset in the middle of a packet
    @(negedge clk);
    drive(VECS[0], 1'b0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    m_tready = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    check(m_tvalid === 1'b0, "R1", "tvalid after mid-packet reset", m_tvalid, 0);
    check(busy === 1'b0, "R1", "busy after mid-packet reset", busy, 0);
    rst_n = 1'b1;
    m_tready = 1'b0;

    // R4: Dword 3 on its own, run again after reset
    run_vec(VECS[2]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule